// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a storage controller's packet command when the data phase runs in programmed I/O. The host programs a transfer size limit, issues the packet opcode and writes a 12-byte command through the 16-bit data port. The sequencer decodes a READ(10) request and returns the requested 2048-byte logical blocks through the same data port. It splits the data into bursts no larger than the programmed limit. Status bits and an interrupt line tell the host when to write the packet, when each burst is ready, and when the command has finished.

Block contents come from a computed pattern, so no media storage is needed. The states are `ST_IDLE` (ready, waiting for a command), `ST_PKT` (requesting the packet), `ST_DECODE` (busy, checking the packet), `ST_SETUP` (busy, sizing the next burst) and `ST_XFER` (a burst is ready for the host). The transitions are:
- IDLE→PKT on the packet opcode.
- PKT→DECODE on the sixth packet word.
- DECODE→IDLE for a rejected or empty request.
- DECODE→SETUP for a valid request.
- SETUP→XFER always.
- XFER→SETUP when a burst is drained and data remains.
- XFER→IDLE when the final word is read.

A flag records whether the host asked for a DMA data phase.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, status (address 7) reads 0x40, the interrupt is low, the count registers (addresses 4 and 5) read 0, and the DMA flag is low.
- R2: In idle, writing 0xA0 to address 7 latches the limit {addr5, addr4} with bit 0 cleared. The next edge shows status 0x48 (DRDY|DRQ), with BSY clear and no interrupt.
- R3: The packet is taken as six writes to address 0, with the low byte first in each word. On the edge after the sixth word, status reads 0xC0 (BSY|DRDY). BSY and DRQ are never both set.
- R4: A READ(10) packet has opcode 0x28 in byte 0, a big-endian LBA in bytes 2–5 and a big-endian block count in bytes 7–8. Data word n of the transfer equals {B, 8'h00} ^ (n mod 1024) ^ 0xC3A5. B is the XOR of the four bytes of (LBA + n/1024).
- R5: Before each burst, the interrupt rises together with status 0x48. Addresses 4 and 5 then hold the burst's byte count, which is min(bytes remaining, limit). The first burst is ready on the second edge after the sixth packet word. Each later burst is ready one edge after the last word of the previous burst.
- R6: The edge that consumes the final data word raises the completion interrupt. After that edge, status reads 0x40.
- R7: Reading status clears the interrupt. A raise in the same cycle takes precedence over the clear.
- R8: An opcode other than 0x28, or LBA + count greater than MEDIA_BLOCKS, ends the command on the edge after the sixth word. The interrupt rises, status reads 0x41, DRQ stays clear and the data port reads 0.
- R9: Feature register (address 1) bit 0 set at the time of the command drives `dma_mode` high until the command ends.
- R10: These writes are ignored: command values other than 0xA0, command writes outside idle, data writes outside the packet phase, and count-register writes outside idle.
- R11: A programmed limit that rounds down to 0 is used as 2.
- R12: A block count of 0 completes on the edge after the sixth word with the interrupt and status 0x40, and has no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (has side effects for data and status) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from address and state |
| intrq | output | 1 | Interrupt request |
| dma_mode | output | 1 | The host requested a DMA data phase |

## Verification
Read data is combinational, so a register read returns its value in the cycle the strobe is held. The side effects of the read (popping a word, clearing the interrupt) land on the following edge.
- The packet request is due one edge after the command write.
- A rejected or empty request completes one edge after the sixth packet word.
- The first burst is due two edges after the sixth packet word.
- Each following burst is due one edge after the previous burst drains.
- The completion interrupt lands on the same edge as the final data read.

The bench drives on falling edges and waits exactly those numbers of edges before it samples, so a result that arrives one cycle late or early is reported.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PKT,
        ST_DECODE,
        ST_SETUP,
        ST_XFER
    } seq_state_t;

    localparam logic [7:0] OP_PACKET = 8'hA0;
    localparam logic [7:0] OP_READ10 = 8'h28;
    localparam int         PKT_WORDS = 6;

    localparam logic [7:0] SB_BSY  = 8'h80;
    localparam logic [7:0] SB_DRDY = 8'h40;
    localparam logic [7:0] SB_DRQ  = 8'h08;
    localparam logic [7:0] SB_ERR  = 8'h01;

    localparam logic [2:0] RA_DATA    = 3'd0;
    localparam logic [2:0] RA_FEAT    = 3'd1;
    localparam logic [2:0] RA_CNT_LO  = 3'd4;
    localparam logic [2:0] RA_CNT_HI  = 3'd5;
    localparam logic [2:0] RA_CMDSTAT = 3'd7;

    localparam logic [15:0] PAT_XOR = 16'hC3A5;
endpackage

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture
    import atapi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic [15:0] wdata,
    output logic        last,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] nblk
);
    localparam int IDX_W = $clog2(PKT_WORDS + 1);

    logic [IDX_W-1:0] idx_q;

    assign last = push && (idx_q == IDX_W'(PKT_WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            opcode <= '0;
            lba    <= '0;
            nblk   <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (push) begin
            idx_q <= idx_q + 1'b1;
            // byte 2k arrives in the low half of word k
            case (idx_q)
                IDX_W'(0): opcode <= wdata[7:0];
                IDX_W'(1): begin
                    lba[31:24] <= wdata[7:0];
                    lba[23:16] <= wdata[15:8];
                end
                IDX_W'(2): begin
                    lba[15:8] <= wdata[7:0];
                    lba[7:0]  <= wdata[15:8];
                end
                IDX_W'(3): nblk[15:8] <= wdata[15:8];
                IDX_W'(4): nblk[7:0]  <= wdata[7:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/atapi_burst_calc.sv
module atapi_burst_calc #(
    parameter int REM_W = 27
) (
    input  logic [REM_W-1:0] rem,
    input  logic [15:0]      limit,
    output logic [15:0]      burst
);
    assign burst = (rem < REM_W'(limit)) ? rem[15:0] : limit;
endmodule

// File: rtl/atapi_pattern_src.sv
module atapi_pattern_src
    import atapi_seq_pkg::*;
#(
    parameter int WPOS_W     = 26,
    parameter int WORD_SHIFT = 10
) (
    input  logic [31:0]       lba,
    input  logic [WPOS_W-1:0] wpos,
    output logic [15:0]       word
);
    logic [31:0]           blk;
    logic [7:0]            blk8;
    logic [WORD_SHIFT-1:0] widx;

    assign blk  = lba + 32'(wpos >> WORD_SHIFT);
    assign blk8 = blk[7:0] ^ blk[15:8] ^ blk[23:16] ^ blk[31:24];
    assign widx = wpos[WORD_SHIFT-1:0];
    assign word = {blk8, 8'h00} ^ 16'(widx) ^ PAT_XOR;
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLOCK_BYTES  = 2048,
    parameter int MEDIA_BLOCKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        intrq,
    output logic        dma_mode
);
    localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);
    localparam int REM_W     = 16 + BLK_SHIFT;
    localparam int WPOS_W    = REM_W - 1;

    seq_state_t state_q, state_d;

    logic [7:0]        feat_q, cnt_lo_q, cnt_hi_q;
    logic [15:0]       limit_q, burst_left_q, burst_sz, lim_raw;
    logic [31:0]       lba_q;
    logic [REM_W-1:0]  rem_q;
    logic [WPOS_W-1:0] wpos_q;
    logic              irq_q, dma_q, err_q;

    logic              cmd_go, data_push, data_pop, stat_rd;
    logic              pkt_last;
    logic [7:0]        pk_op;
    logic [31:0]       pk_lba;
    logic [15:0]       pk_nblk;
    logic [32:0]       end_blk;
    logic              dec_bad, dec_empty, last_in_burst, last_word;
    logic [15:0]       pat_word;
    logic [7:0]        status_byte;

    assign cmd_go    = (state_q == ST_IDLE) && host_wr && (host_addr == RA_CMDSTAT)
                       && (host_wdata[7:0] == OP_PACKET);
    assign data_push = (state_q == ST_PKT) && host_wr && (host_addr == RA_DATA);
    assign data_pop  = (state_q == ST_XFER) && host_rd && (host_addr == RA_DATA);
    assign stat_rd   = host_rd && (host_addr == RA_CMDSTAT);

    atapi_pkt_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd_go),
        .push   (data_push),
        .wdata  (host_wdata),
        .last   (pkt_last),
        .opcode (pk_op),
        .lba    (pk_lba),
        .nblk   (pk_nblk)
    );

    atapi_burst_calc #(.REM_W(REM_W)) u_burst (
        .rem   (rem_q),
        .limit (limit_q),
        .burst (burst_sz)
    );

    atapi_pattern_src #(.WPOS_W(WPOS_W), .WORD_SHIFT(BLK_SHIFT - 1)) u_pattern (
        .lba  (lba_q),
        .wpos (wpos_q),
        .word (pat_word)
    );

    assign end_blk       = {1'b0, pk_lba} + 33'(pk_nblk);
    assign dec_bad       = (pk_op != OP_READ10) || (end_blk > 33'(MEDIA_BLOCKS));
    assign dec_empty     = (pk_nblk == 16'd0);
    assign last_in_burst = (burst_left_q == 16'd2);
    assign last_word     = (rem_q == REM_W'(2));
    assign lim_raw       = {cnt_hi_q, cnt_lo_q[7:1], 1'b0};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_go) state_d = ST_PKT;
            ST_PKT:    if (pkt_last) state_d = ST_DECODE;
            ST_DECODE: state_d = (dec_bad || dec_empty) ? ST_IDLE : ST_SETUP;
            ST_SETUP:  state_d = ST_XFER;
            ST_XFER:   if (data_pop && last_in_burst)
                           state_d = last_word ? ST_IDLE : ST_SETUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q       <= '0;
            cnt_lo_q     <= '0;
            cnt_hi_q     <= '0;
            limit_q      <= 16'd2;
            burst_left_q <= '0;
            lba_q        <= '0;
            rem_q        <= '0;
            wpos_q       <= '0;
            irq_q        <= 1'b0;
            dma_q        <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && host_wr) begin
                unique case (host_addr)
                    RA_FEAT:   feat_q   <= host_wdata[7:0];
                    RA_CNT_LO: cnt_lo_q <= host_wdata[7:0];
                    RA_CNT_HI: cnt_hi_q <= host_wdata[7:0];
                    default: ;
                endcase
            end
            if (stat_rd) irq_q <= 1'b0;
            if (cmd_go) begin
                limit_q <= (lim_raw == 16'd0) ? 16'd2 : lim_raw;
                dma_q   <= feat_q[0];
                err_q   <= 1'b0;
                irq_q   <= 1'b0;
            end
            if (state_q == ST_DECODE) begin
                rem_q  <= REM_W'(pk_nblk) << BLK_SHIFT;
                wpos_q <= '0;
                lba_q  <= pk_lba;
                if (dec_bad || dec_empty) begin
                    err_q <= dec_bad;
                    irq_q <= 1'b1;
                    dma_q <= 1'b0;
                end
            end
            if (state_q == ST_SETUP) begin
                burst_left_q         <= burst_sz;
                {cnt_hi_q, cnt_lo_q} <= burst_sz;
                irq_q                <= 1'b1;
            end
            if (data_pop) begin
                wpos_q       <= wpos_q + 1'b1;
                rem_q        <= rem_q - REM_W'(2);
                burst_left_q <= burst_left_q - 16'd2;
                if (last_in_burst && last_word) begin
                    irq_q <= 1'b1;
                    dma_q <= 1'b0;
                end
            end
        end
    end

    // host-visible views
    always_comb begin
        status_byte = SB_DRDY;
        if (state_q == ST_DECODE || state_q == ST_SETUP) status_byte = status_byte | SB_BSY;
        if (state_q == ST_PKT || state_q == ST_XFER)     status_byte = status_byte | SB_DRQ;
        if (err_q)                                       status_byte = status_byte | SB_ERR;
    end

    always_comb begin
        unique case (host_addr)
            RA_DATA:    host_rdata = (state_q == ST_XFER) ? pat_word : 16'h0000;
            RA_FEAT:    host_rdata = {8'h00, feat_q};
            RA_CNT_LO:  host_rdata = {8'h00, cnt_lo_q};
            RA_CNT_HI:  host_rdata = {8'h00, cnt_hi_q};
            RA_CMDSTAT: host_rdata = {8'h00, status_byte};
            default:    host_rdata = 16'h0000;
        endcase
    end

    assign intrq    = irq_q;
    assign dma_mode = dma_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
    import atapi_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input seq_state_t  state_q,
    input logic [7:0]  status_byte,
    input logic        intrq,
    input logic        host_rd,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic [15:0] burst_left_q,
    input logic [15:0] limit_q,
    input logic        err_q
);
    p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_byte[7] && status_byte[3]));

    p_cmd_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && host_wr && host_addr == 3'd7 && host_wdata[7:0] == 8'hA0)
        |=> (state_q == ST_PKT && !intrq && status_byte == 8'h48));

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd7 && (state_q == ST_PKT || state_q == ST_IDLE))
        |=> !intrq);

    p_burst_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP)
        |=> (intrq && state_q == ST_XFER && burst_left_q != 16'd0
             && !burst_left_q[0] && burst_left_q <= limit_q));

    p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (!status_byte[3] && status_byte[0]));

    p_limit_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (!limit_q[0] && limit_q != 16'd0));
endmodule

bind atapi_pio_seq atapi_pio_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .status_byte  (status_byte),
    .intrq        (intrq),
    .host_rd      (host_rd),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .burst_left_q (burst_left_q),
    .limit_q      (limit_q),
    .err_q        (err_q)
);

// File: tb/atapi_pio_seq_bench.sv
module atapi_pio_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        intrq;
    logic        dma_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    atapi_pio_seq u_atapi_pio_seq (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .intrq(intrq), .dma_mode(dma_mode)
    );

    localparam int NV = 4;
    localparam int unsigned TV_LIM [NV] = '{5120, 5121, 32'h0FFF, 1};
    localparam int unsigned TV_LBA [NV] = '{0, 2, 14, 5};
    localparam int unsigned TV_NBLK[NV] = '{1, 10, 2, 1};
    localparam int unsigned TV_FEAT[NV] = '{0, 0, 1, 0};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [15:0] pat(int unsigned lba, int unsigned wpos);
        logic [31:0] blk;
        logic [7:0]  b8;
        blk = lba + wpos / 1024;
        b8  = blk[7:0] ^ blk[15:8] ^ blk[23:16] ^ blk[31:24];
        return {b8, 8'h00} ^ 16'(wpos % 1024) ^ 16'hC3A5;
    endfunction

    // issues the command and packet; returns one edge after the sixth word
    task automatic send_cmd(int unsigned lim, int unsigned feat, logic [7:0] op,
                            int unsigned lba, int unsigned nblk);
        logic [15:0] d;
        logic [7:0]  b [12];
        for (int i = 0; i < 12; i++) b[i] = 8'h00;
        b[0] = op;
        b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
        b[7] = nblk[15:8]; b[8] = nblk[7:0];
        wr(3'd1, 16'(feat));
        wr(3'd4, {8'h00, lim[7:0]});
        wr(3'd5, {8'h00, lim[15:8]});
        wr(3'd7, 16'h00A0);
        check("R2 intrq after command", 32'(intrq), 0);
        rd(3'd7, d);
        check("R2 packet request status", 32'(d), 32'h48);
        for (int k = 0; k < 6; k++) wr(3'd0, {b[2*k+1], b[2*k]});
        rd(3'd7, d);
        check("R3 busy after packet", 32'(d), 32'hC0);
    endtask

    task automatic run_xfer(int unsigned lim, int unsigned lba, int unsigned nblk,
                            int unsigned feat);
        int unsigned eff, rem, burst, wpos;
        logic [15:0] d, lo, hi;
        logic [15:0] bad_act, bad_exp;
        eff = lim & 32'hFFFE;
        if (eff == 0) eff = 2;   // R11
        rem = nblk * 2048;
        wpos = 0;
        send_cmd(lim, feat, 8'h28, lba, nblk);
        while (rem > 0) begin
            @(negedge clk);
            burst = (rem < eff) ? rem : eff;
            check("R5 burst interrupt", 32'(intrq), 1);
            check("R9 dma flag", 32'(dma_mode), feat & 1);
            rd(3'd4, lo);
            rd(3'd5, hi);
            check("R5 burst byte count", {hi[7:0], lo[7:0]}, burst);
            rd(3'd7, d);
            check("R5 burst status", 32'(d), 32'h48);
            check("R7 status read clears intrq", 32'(intrq), 0);
            bad_act = 16'h0; bad_exp = 16'h0;
            for (int w = 0; w < int'(burst / 2); w++) begin
                rd(3'd0, d);
                if (d !== pat(lba, wpos) && bad_act == bad_exp) begin
                    bad_act = d; bad_exp = pat(lba, wpos);
                end
                wpos++;
            end
            check("R4 data pattern", 32'(bad_act), 32'(bad_exp));
            rem = rem - burst;
        end
        check("R6 completion interrupt", 32'(intrq), 1);
        rd(3'd7, d);
        check("R6 completion status", 32'(d), 32'h40);
        check("R9 dma flag cleared", 32'(dma_mode), 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 intrq", 32'(intrq), 0);
        check("R1 dma flag", 32'(dma_mode), 0);
        rd(3'd7, d); check("R1 status", 32'(d), 32'h40);
        rd(3'd4, d); check("R1 count lo", 32'(d), 0);
        rd(3'd5, d); check("R1 count hi", 32'(d), 0);

        // R10 ignored writes in idle
        wr(3'd7, 16'h00EC);
        wr(3'd0, 16'h1234);
        check("R10 no interrupt on other opcode", 32'(intrq), 0);
        rd(3'd7, d); check("R10 status unchanged", 32'(d), 32'h40);

        // table of transfers
        for (int v = 0; v < NV; v++)
            run_xfer(TV_LIM[v], TV_LBA[v], TV_NBLK[v], TV_FEAT[v]);

        // R12 zero block count
        send_cmd(5120, 0, 8'h28, 3, 0);
        check("R12 completion interrupt", 32'(intrq), 1);
        rd(3'd7, d); check("R12 status", 32'(d), 32'h40);

        // R8 unsupported opcode
        send_cmd(5120, 0, 8'h12, 0, 1);
        check("R8 interrupt on bad opcode", 32'(intrq), 1);
        rd(3'd7, d); check("R8 error status bad opcode", 32'(d), 32'h41);
        rd(3'd0, d); check("R8 no data", 32'(d), 0);

        // R8 beyond media
        send_cmd(5120, 0, 8'h28, 15, 2);
        check("R8 interrupt on range", 32'(intrq), 1);
        rd(3'd7, d); check("R8 error status range", 32'(d), 32'h41);
        rd(3'd7, d); check("R8 still no DRQ", 32'(d), 32'h41);

        // R10 writes during a data phase; ERR cleared by new command (R2)
        send_cmd(5120, 0, 8'h28, 0, 1);
        @(negedge clk);
        wr(3'd4, 16'h0033);
        wr(3'd7, 16'h00A0);
        wr(3'd0, 16'h5555);
        rd(3'd4, d); check("R10 count reg kept", 32'(d), 32'h00);
        rd(3'd5, d); check("R10 count hi kept", 32'(d), 32'h08);
        rd(3'd7, d); check("R10 still in data phase", 32'(d), 32'h48);
        rd(3'd0, d); check("R10 first word intact", 32'(d), 32'(pat(0, 0)));
        for (int w = 1; w < 1024; w++) rd(3'd0, d);
        check("R6 completion after directed run", 32'(intrq), 1);
        rd(3'd7, d); check("R6 final status", 32'(d), 32'h40);

        finish_up();
    end
endmodule